// File: doc/BRIEF.md
# Periodic Down-Counting Timer Channel

This block is one timer channel with a 32-bit down-counter and two modes. In compare mode, software programs a start value and enables the channel. The counter loads that value and steps down by one on each cycle where the tick-enable input is high. When it would reach zero, it raises a sticky interrupt, reloads the programmed value and keeps running. The programmed value is held apart from the counter. A new value written during a period therefore only takes effect at the next reload. To restart at once with a new value, software disables the channel and then enables it again.

In capture mode, the counter starts from all ones when the channel is enabled and runs down freely, wrapping. Each rising edge of the trigger input stores the bitwise inverse of the counter into the value register. The stored value equals the number of ticks seen since the channel was enabled.

Software reaches the block through a simple single-cycle write port and a combinational read port. The interrupt and error bits are cleared by writing one to them.

Top module: `dtmr_channel`

## Requirements
- R1: After reset, the control, value, count and status words all read zero, and `irq` is low.
- R2: Enabling in compare mode with a value V of at least 2 loads the count with V. Each cycle with `tick_en` high lowers the count by one. A cycle with `tick_en` low leaves the count unchanged.
- R3: A tick while the count is 1 is an expiry. It reloads the count from the value register and sets the sticky interrupt, so a period lasts V ticks and counting continues.
- R4: Writing the value word while the channel runs leaves the count untouched. The new value is first used at the next expiry.
- R5: Writing the enable bit to 0 freezes the count and keeps the interrupt set. Writing enable 1 again loads the value register into the count at once. Writing enable 1 while the channel is already enabled does not reload.
- R6: Enabling in capture mode loads the count with all ones, and each tick lowers it by one. On a rising edge of `trig`, the value word takes the bitwise inverse of the count as it stood before that edge. A trigger held high captures only once. Capture mode never sets the interrupt.
- R7: Enabling in compare mode with a value of 0 or 1 leaves the channel disabled and the count unchanged, and sets the error bit.
- R8: If an expiry finds a value of 0 or 1 in the value register, the channel disables itself and sets both the error bit and the interrupt.
- R9: Writing the status word with bit 0 set clears the interrupt, and with bit 1 set clears the error. Zero bits have no effect. An interrupt or error raised in the same cycle as its clear takes priority, so the bit stays set.
- R10: Word addresses are 0 for control, 1 for value, 2 for count (read only) and 3 for status. Control bit 0 is enable and bit 1 is mode (0 compare, 1 capture); the mode bit is taken only while the channel is disabled. Status bit 0 is the interrupt and bit 1 is the error. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| tick_en | input | 1 | Counter step enable |
| trig | input | 1 | Capture trigger, synchronous to clk |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench writes a new value in the middle of a period. A design that restarted the period on that write would show a reloaded count at once, instead of at the next expiry. Disabling and re-enabling checks both halves of that behaviour: the count must freeze while disabled, and enabling must load at once. An enable written while the channel already runs must not reload. The bench also tries illegal start values 0 and 1, and an illegal value that is only discovered at reload; a design that counted from 0 would stall or wrap instead of flagging the error. In capture mode, a trigger is held high across several ticks; a level-sensitive capture would keep overwriting the value word. A clear of the interrupt is timed to land on the very edge of an expiry, which exposes a clear that wins over a new set.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int STAT_IRQ_BIT  = 0;
  localparam int STAT_ERR_BIT  = 1;

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_CAP = 1'b1
  } mode_e;
endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              expire,
  input  logic              cap_fire,
  input  logic [W-1:0]      cnt,
  output logic              en,
  output mode_e             mode,
  output logic [W-1:0]      value,
  output logic              irq,
  output logic              err,
  output logic              start,
  output mode_e             start_mode
);
  localparam logic [W-1:0] ONE = W'(1);

  logic   en_q, en_d, irq_q, irq_d, err_q, err_d;
  mode_e  mode_q, mode_d;
  logic [W-1:0] value_q, value_d;

  logic   ctrl_wr, load_wr, stat_wr;
  logic   req_en, value_ok, bad_start, bad_reload;
  mode_e  req_mode;

  always_comb begin
    ctrl_wr    = wr_en && (wr_addr == A_CTRL);
    load_wr    = wr_en && (wr_addr == A_LOAD);
    stat_wr    = wr_en && (wr_addr == A_STAT);
    req_en     = wr_data[CTRL_EN_BIT];
    req_mode   = mode_e'(wr_data[CTRL_MODE_BIT]);
    value_ok   = value_q > ONE;
    start      = ctrl_wr && req_en && !en_q &&
                 ((req_mode == MODE_CAP) || value_ok);
    bad_start  = ctrl_wr && req_en && !en_q &&
                 (req_mode == MODE_CMP) && !value_ok;
    bad_reload = expire && !value_ok;
    start_mode = req_mode;

    en_d = en_q;
    if (ctrl_wr)    en_d = req_en && (en_q || start);
    if (bad_reload) en_d = 1'b0;

    mode_d = (ctrl_wr && !en_q) ? req_mode : mode_q;

    if (cap_fire)     value_d = ~cnt;
    else if (load_wr) value_d = wr_data;
    else              value_d = value_q;

    irq_d = expire | (irq_q & ~(stat_wr & wr_data[STAT_IRQ_BIT]));
    err_d = bad_start | bad_reload |
            (err_q & ~(stat_wr & wr_data[STAT_ERR_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= MODE_CMP;
      value_q <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      value_q <= value_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  assign en    = en_q;
  assign mode  = mode_q;
  assign value = value_q;
  assign irq   = irq_q;
  assign err   = err_q;
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  mode_e        mode,
  input  logic         start,
  input  mode_e        start_mode,
  input  logic [W-1:0] value,
  input  logic         tick,
  input  logic         trig_rise,
  output logic [W-1:0] cnt,
  output logic         expire,
  output logic         cap_fire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step     = en && tick;
    expire   = step && (mode == MODE_CMP) && (cnt_q == ONE);
    cap_fire = en && (mode == MODE_CAP) && trig_rise;

    cnt_d = cnt_q;
    if (start)       cnt_d = (start_mode == MODE_CAP) ? '1 : value;
    else if (expire) cnt_d = value;
    else if (step)   cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              tick_en,
  input  logic              trig,
  output logic              irq
);
  logic         ch_en, ch_err, ch_start, ch_expire, ch_cap, trig_rise;
  mode_e        ch_mode, ch_start_mode;
  logic [W-1:0] ch_value, ch_cnt;

  dtmr_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (trig),
    .rise (trig_rise)
  );

  dtmr_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .expire    (ch_expire),
    .cap_fire  (ch_cap),
    .cnt       (ch_cnt),
    .en        (ch_en),
    .mode      (ch_mode),
    .value     (ch_value),
    .irq       (irq),
    .err       (ch_err),
    .start     (ch_start),
    .start_mode(ch_start_mode)
  );

  dtmr_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ch_en),
    .mode      (ch_mode),
    .start     (ch_start),
    .start_mode(ch_start_mode),
    .value     (ch_value),
    .tick      (tick_en),
    .trig_rise (trig_rise),
    .cnt       (ch_cnt),
    .expire    (ch_expire),
    .cap_fire  (ch_cap)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL: begin
        rd_data[CTRL_EN_BIT]   = ch_en;
        rd_data[CTRL_MODE_BIT] = ch_mode;
      end
      A_LOAD:  rd_data = ch_value;
      A_COUNT: rd_data = ch_cnt;
      A_STAT: begin
        rd_data[STAT_IRQ_BIT] = irq;
        rd_data[STAT_ERR_BIT] = ch_err;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic              tick_en,
  input logic              en,
  input logic              mode,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      value,
  input logic              irq,
  input logic              err,
  input logic              expire,
  input logic              cap_fire,
  input logic              start
);
  localparam logic [W-1:0] ONE = W'(1);

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_CMP && tick_en && cnt > ONE) |=> cnt == $past(cnt) - ONE);

  p_expire_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (irq && cnt == $past(value)));

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_en) |=> $stable(cnt));

  p_frozen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> $stable(cnt));

  p_capture_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> value == ~$past(cnt));

  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !en);

  p_no_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_CMP) |-> cnt != '0);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == A_STAT && wr_data[STAT_IRQ_BIT])) |=> irq);
endmodule

bind dtmr_channel dtmr_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .tick_en (tick_en),
  .en      (ch_en),
  .mode    (ch_mode),
  .cnt     (ch_cnt),
  .value   (ch_value),
  .irq     (irq),
  .err     (ch_err),
  .expire  (ch_expire),
  .cap_fire(ch_cap),
  .start   (ch_start)
);

// File: tb/sim_dtmr_channel.sv
module sim_dtmr_channel;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] AC = 2'd0, AV = 2'd1, AN = 2'd2, AS = 2'd3;

  logic        clk, rst_n, wr_en, tick_en, trig, irq;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  dtmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_en(tick_en), .trig(trig), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] c, input logic [31:0] v, input bit t);
    if (!t) return c;
    return (c == 32'd1) ? v : c - 32'd1;
  endfunction

  function automatic bit model_exp(input logic [31:0] c, input bit t);
    return t && (c == 32'd1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] m, v, snap;
    bit mi;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; tick_en = 1'b0; trig = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg("R1 ctrl", AC, 0);
    chk_reg("R1 value", AV, 0);
    chk_reg("R1 count", AN, 0);
    chk_reg("R1 status", AS, 0);
    check("R1 irq", irq, 0);

    // R2 load and step
    wr(AV, 5);
    wr(AC, 1);
    chk_reg("R2 load", AN, 5);
    chk_reg("R10 ctrl enabled", AC, 1);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk_reg("R2 hold without tick", AN, 5);
    run_ticks(3);
    chk_reg("R2 three ticks", AN, 2);
    check("R2 no irq yet", irq, 0);

    // R3 expiry
    run_ticks(2);
    chk_reg("R3 reload", AN, 5);
    check("R3 irq set", irq, 1);

    // R4 value write mid-period
    wr(AV, 9);
    chk_reg("R4 count untouched", AN, 5);
    chk_reg("R4 value stored", AV, 9);

    // R9 clear rules
    wr(AS, 0);
    check("R9 zero write keeps irq", irq, 1);
    wr(AS, 1);
    check("R9 w1c clears irq", irq, 0);

    run_ticks(4);
    chk_reg("R4 old period continues", AN, 1);
    check("R4 no early irq", irq, 0);
    run_ticks(1);
    chk_reg("R4 new value at reload", AN, 9);
    check("R3 irq on expiry", irq, 1);

    // R5 disable freezes, re-enable restarts
    run_ticks(3);
    wr(AC, 0);
    chk_reg("R5 disabled", AC, 0);
    run_ticks(4);
    chk_reg("R5 count frozen", AN, 6);
    check("R5 irq kept", irq, 1);
    wr(AV, 4);
    wr(AC, 1);
    chk_reg("R5 restart loads", AN, 4);
    run_ticks(1);
    wr(AC, 1);
    chk_reg("R5 enable while running no reload", AN, 3);
    wr(AC, 3);
    chk_reg("R10 mode locked while enabled", AC, 1);

    // R2 R3 random ticking against model
    wr(AC, 0);
    for (int r = 0; r < 6; r++) begin
      v = 32'd2 + ($urandom % 30);
      wr(AS, 3);
      wr(AV, v);
      wr(AC, 1);
      m = v; mi = 0;
      for (int c = 0; c < 60; c++) begin
        bit t;
        t = $urandom % 2;
        tick_en = t;
        @(posedge clk);
        @(negedge clk);
        mi = mi | model_exp(m, t);
        m = model_next(m, v, t);
        tick_en = 1'b0;
        chk_reg("R2 random count", AN, m);
        check("R3 random irq", irq, mi);
      end
      wr(AC, 0);
    end
    wr(AS, 3);

    // R7 illegal start values
    rd(AN, snap);
    wr(AV, 1);
    wr(AC, 1);
    chk_reg("R7 start 1 stays off", AC, 0);
    chk_reg("R7 error set", AS, 2);
    chk_reg("R7 count unchanged", AN, snap);
    wr(AS, 2);
    chk_reg("R9 error cleared", AS, 0);
    wr(AV, 0);
    wr(AC, 1);
    chk_reg("R7 start 0 stays off", AC, 0);
    chk_reg("R7 error set again", AS, 2);
    wr(AS, 2);

    // R8 illegal reload
    wr(AV, 3);
    wr(AC, 1);
    wr(AV, 0);
    run_ticks(3);
    chk_reg("R8 self disable", AC, 0);
    chk_reg("R8 error and irq", AS, 3);
    wr(AS, 3);

    // R6 capture
    wr(AC, 3);
    chk_reg("R6 capture enabled", AC, 3);
    chk_reg("R6 load all ones", AN, 32'hFFFF_FFFF);
    run_ticks(7);
    chk_reg("R6 free run", AN, 32'hFFFF_FFF8);
    trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    chk_reg("R6 capture inverse", AV, 7);
    run_ticks(5);
    trig = 1'b1; tick_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    trig = 1'b0; tick_en = 1'b0;
    chk_reg("R6 held trigger one capture", AV, 12);
    chk_reg("R6 count after held", AN, 32'hFFFF_FFEF);
    run_ticks(2);
    chk_reg("R6 no capture without edge", AV, 12);
    check("R6 no irq in capture", irq, 0);

    // R9 set wins over clear
    wr(AC, 0);
    wr(AV, 2);
    wr(AC, 1);
    chk_reg("R10 mode compare after restart", AC, 1);
    run_ticks(1);
    chk_reg("R9 setup count", AN, 1);
    wr_en = 1'b1; wr_addr = AS; wr_data = 32'd1; tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    check("R9 set beats clear", irq, 1);
    chk_reg("R9 reload on that edge", AN, 2);
    wr(AS, 1);
    check("R9 later clear", irq, 0);

    finish_run();
  end
endmodule